// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events for a small 4-bit processor core and decides which one the core takes next. It has eight priority levels. Level 0 has the lowest priority and level 7 the highest. Eleven hardware event lines each pass through their own enable bit and are then grouped onto levels 1 to 7. Several lines can share one level. Level 0 has no hardware line. Software reaches it, and any other level, through a write port. Each bit of that port sets the pending flag of the matching level, so software can raise a level early or leave work for later at a lower level. A flag set this way behaves exactly like one set by hardware.

The pending flags go through a fixed priority pick. While anything is pending, the block shows the highest pending level's entry address and its one-byte short-call opcode. The request line is the OR of all pending flags, gated by a global enable. When the core acknowledges a taken request, only the flag of the level being shown is cleared. Lower flags keep their state and are served afterwards in descending order.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, no level is pending, `irqOut` is 0, and `vecOut` and `opcodeOut` are both zero.
- R2: A source event whose `srcEnable` bit is 0 never sets a pending flag. An enabled event sets its level's flag, and this is visible after the next rising clock edge. The source-to-level map is: sources 0 and 1 to level 1, source 2 to level 2, source 3 to level 3, source 4 to level 4, sources 5 to 7 to level 5, sources 8 and 9 to level 6, and source 10 to level 7.
- R3: A pending flag stays set over any number of cycles until its level is acknowledged.
- R4: An acknowledge counts only when `ackIn` and `irqOut` are both high in the same cycle. It then clears the flag of the level being shown at the next edge, and all other flags keep their state. An acknowledge while `irqOut` is low has no effect.
- R5: When `swWrEn` is high, each 1 in `swWrData` (bit i for level i) sets that level's flag at the next edge. Zeros never clear a flag.
- R6: `irqOut` is high exactly when `globalEn` is high and at least one flag is pending. With `globalEn` low, the pending flags are kept.
- R7: While any flag is pending, `vecOut` and `opcodeOut` show the highest pending level's values, whatever the state of `globalEn`. With nothing pending, both outputs are zero. The entry addresses for levels 0 to 7 are 040h, 080h, 0C0h, 100h, 140h, 180h, 1C0h and 1E0h. The opcodes for levels 0 to 7 are C8h, D0h, D8h, E8h, E8h, F0h, F8h and FCh.
- R8: If an enabled hardware event or a software write sets the level being acknowledged in the same cycle, that level's flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcEvent | input | 11 | One-cycle hardware event pulses, one per source |
| srcEnable | input | 11 | Per-source enable (1 lets the event through) |
| swWrEn | input | 1 | Software pending-write strobe |
| swWrData | input | 8 | Levels to set on a software write, bit i for level i |
| globalEn | input | 1 | Global interrupt enable that gates the request |
| ackIn | input | 1 | Core acknowledge of the request being shown |
| irqOut | output | 1 | Interrupt request to the core |
| vecOut | output | 9 | Entry address of the highest pending level |
| opcodeOut | output | 8 | Short-call opcode of the highest pending level |

## Verification
The bench builds the block with its default parameters: eight levels, eleven sources, and the default source map, address list and opcode list. With these values every source-to-level mapping, every entry address and every opcode can be reached at the ports. A per-source loop walks each line through its level. The vector table then drives the cases where order matters: priority between levels, an acknowledge that lands on a flag being set in the same cycle, and an acknowledge refused because the enable is low.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Widest level index the shared strobe type can carry.
  localparam int unsigned LEVEL_W = 3;

  typedef logic [LEVEL_W-1:0] level_t;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic   clrValid;
    level_t clrLevel;
  } ctl_strobe_t;

endpackage

// File: rtl/irq_prio_control.sv
module irq_prio_control
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8
) (
  input  logic [NUM_LEVELS-1:0] pendingQ,
  input  logic                  globalEn,
  input  logic                  ackIn,
  output level_t                grantLevel,
  output logic                  irqOut,
  output ctl_strobe_t           strobes
);

  logic anyPending;

  // Fixed priority: a higher index overrides a lower one.
  always_comb begin
    grantLevel = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (pendingQ[i]) grantLevel = level_t'(i);
    end
  end

  assign anyPending       = |pendingQ;
  assign irqOut           = globalEn & anyPending;
  assign strobes.clrValid = ackIn & irqOut;
  assign strobes.clrLevel = grantLevel;

endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned NUM_SRC    = 11,
  parameter int unsigned VEC_W      = 9,
  parameter int unsigned OP_W       = 8,
  parameter logic [NUM_SRC*LEVEL_W-1:0]  SRC_LEVEL = '0,
  parameter logic [NUM_LEVELS*VEC_W-1:0] VECTORS   = '0,
  parameter logic [NUM_LEVELS*OP_W-1:0]  OPCODES   = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcEvent,
  input  logic [NUM_SRC-1:0]    srcEnable,
  input  logic                  swWrEn,
  input  logic [NUM_LEVELS-1:0] swWrData,
  input  ctl_strobe_t           strobes,
  input  level_t                grantLevel,
  output logic [NUM_LEVELS-1:0] pendingQ,
  output logic [VEC_W-1:0]      vecOut,
  output logic [OP_W-1:0]       opcodeOut
);

  logic [NUM_SRC-1:0]    liveEvent;
  logic [NUM_LEVELS-1:0] hwSet;
  logic [NUM_LEVELS-1:0] swSet;
  logic [NUM_LEVELS-1:0] clrMask;
  logic [NUM_LEVELS-1:0] pendingD;

  assign liveEvent = srcEvent & srcEnable;
  assign swSet     = swWrEn ? swWrData : '0;

  // Fan-in of the enabled sources onto their levels.
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    logic [NUM_SRC-1:0] srcSel;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign srcSel[s] = (SRC_LEVEL[s*LEVEL_W +: LEVEL_W] == level_t'(l));
    end
    assign hwSet[l]   = |(liveEvent & srcSel);
    assign clrMask[l] = strobes.clrValid && (strobes.clrLevel == level_t'(l));
  end

  // A set in the same cycle as the clear wins.
  assign pendingD = (pendingQ & ~clrMask) | hwSet | swSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= '0;
    else       pendingQ <= pendingD;
  end

  always_comb begin
    if (pendingQ == '0) begin
      vecOut    = '0;
      opcodeOut = '0;
    end else begin
      vecOut    = VECTORS[grantLevel*VEC_W +: VEC_W];
      opcodeOut = OPCODES[grantLevel*OP_W +: OP_W];
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned NUM_SRC    = 11,
  parameter int unsigned VEC_W      = 9,
  parameter int unsigned OP_W       = 8,
  parameter logic [NUM_SRC*LEVEL_W-1:0] SRC_LEVEL =
    {3'd7, 3'd6, 3'd6, 3'd5, 3'd5, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd1},
  parameter logic [NUM_LEVELS*VEC_W-1:0] VECTORS =
    {9'h1E0, 9'h1C0, 9'h180, 9'h140, 9'h100, 9'h0C0, 9'h080, 9'h040},
  parameter logic [NUM_LEVELS*OP_W-1:0] OPCODES =
    {8'hFC, 8'hF8, 8'hF0, 8'hE8, 8'hE8, 8'hD8, 8'hD0, 8'hC8}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcEvent,
  input  logic [NUM_SRC-1:0]    srcEnable,
  input  logic                  swWrEn,
  input  logic [NUM_LEVELS-1:0] swWrData,
  input  logic                  globalEn,
  input  logic                  ackIn,
  output logic                  irqOut,
  output logic [VEC_W-1:0]      vecOut,
  output logic [OP_W-1:0]       opcodeOut
);

  localparam int unsigned MAX_LEVELS = 1 << LEVEL_W;

  initial begin
    if (NUM_LEVELS > MAX_LEVELS)
      $error("NUM_LEVELS exceeds the width of the level index");
  end

  logic [NUM_LEVELS-1:0] pendingQ;
  level_t                grantLevel;
  ctl_strobe_t           strobes;

  irq_prio_control #(
    .NUM_LEVELS(NUM_LEVELS)
  ) u_control (
    .pendingQ  (pendingQ),
    .globalEn  (globalEn),
    .ackIn     (ackIn),
    .grantLevel(grantLevel),
    .irqOut    (irqOut),
    .strobes   (strobes)
  );

  irq_prio_datapath #(
    .NUM_LEVELS(NUM_LEVELS),
    .NUM_SRC   (NUM_SRC),
    .VEC_W     (VEC_W),
    .OP_W      (OP_W),
    .SRC_LEVEL (SRC_LEVEL),
    .VECTORS   (VECTORS),
    .OPCODES   (OPCODES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .srcEvent  (srcEvent),
    .srcEnable (srcEnable),
    .swWrEn    (swWrEn),
    .swWrData  (swWrData),
    .strobes   (strobes),
    .grantLevel(grantLevel),
    .pendingQ  (pendingQ),
    .vecOut    (vecOut),
    .opcodeOut (opcodeOut)
  );

endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned NUM_SRC    = 11
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_SRC-1:0]    srcEvent,
  input logic [NUM_SRC-1:0]    srcEnable,
  input logic                  swWrEn,
  input logic [NUM_LEVELS-1:0] swWrData,
  input logic                  globalEn,
  input logic                  ackIn,
  input logic                  irqOut,
  input logic [NUM_LEVELS-1:0] pendingQ,
  input level_t                grantLevel
);

  localparam logic [NUM_LEVELS-1:0] ONE = {{(NUM_LEVELS-1){1'b0}}, 1'b1};

  // R2: with no enabled event and no write, an empty register stays empty
  p_masked_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ == '0 && !swWrEn && (srcEvent & srcEnable) == '0) |=> pendingQ == '0);

  // R3: without an accepted acknowledge no flag is lost
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(ackIn && irqOut) |=> (($past(pendingQ) & ~pendingQ) == '0));

  // R4: an accepted acknowledge with nothing setting clears the shown level
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut && !swWrEn && (srcEvent & srcEnable) == '0)
      |=> !pendingQ[$past(grantLevel)]);

  // R5: software bits land in the register
  p_sw_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> ((pendingQ & $past(swWrData)) == $past(swWrData)));

  // R6: a request needs the enable and a pending flag
  p_irq_needs_pend_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (globalEn && pendingQ != '0));

  // R7: the shown level is the highest pending one
  p_grant_highest_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((pendingQ >> grantLevel) == ONE));

  // R8: a coincident software set survives the acknowledge
  p_coincident_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut && swWrEn && swWrData[grantLevel]) |=> pendingQ[$past(grantLevel)]);

endmodule

bind irq_prio_ctrl irq_prio_checker #(
  .NUM_LEVELS(NUM_LEVELS),
  .NUM_SRC   (NUM_SRC)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .srcEvent  (srcEvent),
  .srcEnable (srcEnable),
  .swWrEn    (swWrEn),
  .swWrData  (swWrData),
  .globalEn  (globalEn),
  .ackIn     (ackIn),
  .irqOut    (irqOut),
  .pendingQ  (pendingQ),
  .grantLevel(grantLevel)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [10:0] ALL = 11'h7FF;

  typedef struct packed {
    logic        swEn;
    logic [7:0]  swData;
    logic [10:0] ev;
    logic [10:0] en;
    logic        gEn;
    logic        ack;
    logic        expIrq;
    logic [8:0]  expVec;
    logic [7:0]  expOp;
    logic [3:0]  req;
  } step_t;

  localparam int N_STEPS = 22;
  localparam step_t TABLE [N_STEPS] = '{
    '{1'b0, 8'h00, 11'h001, ALL,     1'b1, 1'b0, 1'b1, 9'h080, 8'hD0, 4'd2}, // R2 src0 -> L1
    '{1'b0, 8'h00, 11'h400, 11'h3FF, 1'b1, 1'b0, 1'b1, 9'h080, 8'hD0, 4'd2}, // R2 masked src10
    '{1'b0, 8'h00, 11'h000, ALL,     1'b0, 1'b0, 1'b0, 9'h080, 8'hD0, 4'd6}, // R6 enable low
    '{1'b1, 8'h01, 11'h000, ALL,     1'b1, 1'b0, 1'b1, 9'h080, 8'hD0, 4'd5}, // R5 set L0
    '{1'b0, 8'h00, 11'h020, ALL,     1'b1, 1'b0, 1'b1, 9'h180, 8'hF0, 4'd7}, // R7 L5 over L1
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b1, 9'h080, 8'hD0, 4'd4}, // R4 clear L5
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b1, 9'h040, 8'hC8, 4'd4}, // R4 clear L1
    '{1'b0, 8'h00, 11'h000, ALL,     1'b0, 1'b1, 1'b0, 9'h040, 8'hC8, 4'd4}, // R4 refused ack
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b0, 9'h000, 8'h00, 4'd4}, // R4 clear L0
    '{1'b1, 8'h80, 11'h000, ALL,     1'b1, 1'b0, 1'b1, 9'h1E0, 8'hFC, 4'd5}, // R5 set L7
    '{1'b0, 8'h00, 11'h400, ALL,     1'b1, 1'b1, 1'b1, 9'h1E0, 8'hFC, 4'd8}, // R8 hw vs ack
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b0, 9'h000, 8'h00, 4'd4},
    '{1'b0, 8'h00, 11'h018, ALL,     1'b1, 1'b0, 1'b1, 9'h140, 8'hE8, 4'd7}, // R7 L4 over L3
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b1, 9'h100, 8'hE8, 4'd4},
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b0, 9'h000, 8'h00, 4'd4},
    '{1'b0, 8'h00, 11'h100, ALL,     1'b1, 1'b0, 1'b1, 9'h1C0, 8'hF8, 4'd2},
    '{1'b1, 8'h40, 11'h000, ALL,     1'b1, 1'b1, 1'b1, 9'h1C0, 8'hF8, 4'd8}, // R8 sw vs ack
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b0, 9'h000, 8'h00, 4'd4},
    '{1'b0, 8'h00, 11'h004, ALL,     1'b1, 1'b0, 1'b1, 9'h0C0, 8'hD8, 4'd2},
    '{1'b0, 8'h00, 11'h000, ALL,     1'b1, 1'b1, 1'b0, 9'h000, 8'h00, 4'd4},
    '{1'b0, 8'h00, ALL,     11'h000, 1'b1, 1'b0, 1'b0, 9'h000, 8'h00, 4'd2}, // R2 all masked
    '{1'b1, 8'h00, 11'h000, ALL,     1'b1, 1'b0, 1'b0, 9'h000, 8'h00, 4'd5}  // R5 zero write
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [10:0] srcEvent;
  logic [10:0] srcEnable;
  logic        swWrEn;
  logic [7:0]  swWrData;
  logic        globalEn;
  logic        ackIn;
  logic        irqOut;
  logic [8:0]  vecOut;
  logic [7:0]  opcodeOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcEvent (srcEvent),
    .srcEnable(srcEnable),
    .swWrEn   (swWrEn),
    .swWrData (swWrData),
    .globalEn (globalEn),
    .ackIn    (ackIn),
    .irqOut   (irqOut),
    .vecOut   (vecOut),
    .opcodeOut(opcodeOut)
  );

  function automatic int srcLevel(input int s);
    case (s)
      0, 1:    return 1;
      2:       return 2;
      3:       return 3;
      4:       return 4;
      5, 6, 7: return 5;
      8, 9:    return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [8:0] levelVec(input int l);
    return (l < 7) ? 9'((l + 1) * 64) : 9'h1E0;
  endfunction

  function automatic logic [7:0] levelOp(input int l);
    case (l)
      0: return 8'hC8;
      1: return 8'hD0;
      2: return 8'hD8;
      3, 4: return 8'hE8;
      5: return 8'hF0;
      6: return 8'hF8;
      default: return 8'hFC;
    endcase
  endfunction

  task automatic check(input int req, input logic eIrq, input logic [8:0] eVec,
                       input logic [7:0] eOp);
    nChecks++;
    if (irqOut !== eIrq || vecOut !== eVec || opcodeOut !== eOp) begin
      nFails++;
      $display("FAIL R%0d: irq=%0b vec=%03h op=%02h, expected irq=%0b vec=%03h op=%02h",
               req, irqOut, vecOut, opcodeOut, eIrq, eVec, eOp);
    end
  endtask

  // Drive one cycle of inputs, let the edge pass, return just after it.
  task automatic step(input logic swEn, input logic [7:0] swData, input logic [10:0] ev,
                      input logic [10:0] en, input logic gEn, input logic ack);
    swWrEn = swEn; swWrData = swData; srcEvent = ev; srcEnable = en;
    globalEn = gEn; ackIn = ack;
    @(posedge clk);
    #1;
    swWrEn = 1'b0; swWrData = '0; srcEvent = '0; ackIn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; srcEvent = '0; srcEnable = ALL; swWrEn = 1'b0; swWrData = '0;
    globalEn = 1'b1; ackIn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(1, 1'b0, 9'h000, 8'h00); // R1 in reset
    rstN = 1'b1;
    @(posedge clk); #1;
    check(1, 1'b0, 9'h000, 8'h00); // R1 after release

    for (int i = 0; i < N_STEPS; i++) begin
      step(TABLE[i].swEn, TABLE[i].swData, TABLE[i].ev, TABLE[i].en,
           TABLE[i].gEn, TABLE[i].ack);
      check(int'(TABLE[i].req), TABLE[i].expIrq, TABLE[i].expVec, TABLE[i].expOp);
    end

    // R2: each source reaches its own level
    for (int s = 0; s < 11; s++) begin
      step(1'b0, 8'h00, 11'(1) << s, ALL, 1'b1, 1'b0);
      check(2, 1'b1, levelVec(srcLevel(s)), levelOp(srcLevel(s)));
      step(1'b0, 8'h00, 11'h000, ALL, 1'b1, 1'b1);
      check(4, 1'b0, 9'h000, 8'h00);
    end

    // R7: every level through software, lowest first, then drained from the top
    for (int l = 0; l < 8; l++) begin
      step(1'b1, 8'(1 << l), 11'h000, ALL, 1'b1, 1'b0);
      check(7, 1'b1, levelVec(l), levelOp(l));
    end
    for (int l = 7; l >= 0; l--) begin
      check(4, 1'b1, levelVec(l), levelOp(l));
      step(1'b0, 8'h00, 11'h000, ALL, 1'b1, 1'b1);
    end
    check(4, 1'b0, 9'h000, 8'h00);

    // R3: a flag held over idle cycles
    step(1'b0, 8'h00, 11'h010, ALL, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 8'h00, 11'h000, ALL, k[0], 1'b0);
      check(3, k[0], 9'h140, 8'hE8);
    end

    // R1: reset in the middle of activity
    rstN = 1'b0;
    #1;
    check(1, 1'b0, 9'h000, 8'h00);
    @(posedge clk); #1;
    rstN = 1'b1;
    step(1'b0, 8'h00, 11'h000, ALL, 1'b1, 1'b0);
    check(1, 1'b0, 9'h000, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule